// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The router collects up to 64 device interrupt lines into one shared raw request register and steers them to up to four CPUs. Each CPU owns an enable mask of the same width. The routed pending vector for a CPU is its mask ANDed with the raw request register. A single level-1 interrupt output per CPU is high whenever that vector has any bit set. Device logic raises or drops individual lines through set and clear strobes that carry a line index.

Software reaches the masks, the routed pending vectors, the raw request register and a sticky access-error flag through a 64-bit CSR port with a 12-bit byte address and a size code. Reads are answered in the same cycle. An access the block does not accept never halts anything. It records the fault in the error flag and changes no other state. A new mask value and a device strobe both take effect on the CPU outputs at the same clock edge that stores them.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask, the raw request register and the error flag read as zero, and all bits of `cpu_irq` are low.
- R2: A read of CPU c's pending register (register number 4+c, or the bulk pending window at index c) returns exactly mask[c] AND raw.
- R3: `dev_set_vld` sets raw bit `dev_set_idx` and `dev_clr_vld` clears raw bit `dev_clr_idx` at the next clock edge. When both strobes name the same line in one cycle, the bit ends up set.
- R4: A clear strobe on a line whose raw bit is already zero leaves the raw register, every pending vector and `cpu_irq` unchanged.
- R5: After each clock edge, `cpu_irq[c]` is 1 exactly when CPU c's pending vector is non-zero. It updates at the same edge as the mask write or strobe that changes the vector, so it rises when a mask bit and its raw bit become set together and falls when the last pending bit goes away.
- R6: Setting a mask bit whose raw bit is zero leaves `cpu_irq` for that CPU unchanged.
- R7: Address decode works in this order. Address bit 11 set selects the bulk mask window. Otherwise bit 10 set selects the bulk pending window. In both windows the CPU index is address bits [9:4]. With bits 11 and 10 both clear, the register number is address bits [9:6]: 0 to 3 are masks, 4 to 7 are pending vectors, 8 is the raw register and 9 is the error register.
- R8: `csr_size` encodes 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Only 64-bit accesses are accepted. The one exception is a 32-bit read of the raw register, which returns raw bits [31:0] with the upper 32 bits zero. Any other size is illegal, changes no mask and returns zero.
- R9: These accesses are illegal and set the sticky error flag: a wrong size, a write to a pending register, a write to the raw register, an undefined register number, and a bulk index of NUM_CPU or more. The flag reads as bit 0 of register 9. It stays set until a 64-bit write to register 9 clears it.
- R10: `csr_rdata` is combinational from the current state while `csr_req` is high with `csr_we` low. It is zero for writes, for illegal accesses and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_set_vld | input | 1 | Strobe that raises one device line |
| dev_set_idx | input | LINE_W | Line raised by the set strobe |
| dev_clr_vld | input | 1 | Strobe that drops one device line |
| dev_clr_idx | input | LINE_W | Line dropped by the clear strobe |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_size | input | 2 | Access size code |
| csr_addr | input | 12 | Byte offset within the CSR space |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, same cycle |
| cpu_irq | output | NUM_CPU | Level-1 interrupt per CPU |

## Verification
The bench builds the block with its defaults of four CPUs and 64 lines. This makes the bulk index boundary at 4 reachable with a 6-bit index field. It also lets the bench place raw bits above bit 31, so the 32-bit read of the raw register shows its upper half forced to zero. With every register number from 0 to 15 and bulk indices up to 7 drawn at random, undefined registers, read-only targets and out-of-range indices all occur next to legal traffic. Each mask then meets a raw register that keeps changing.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int unsigned CSR_ADDR_W    = 12;
  localparam int unsigned CSR_DATA_W    = 64;
  localparam int unsigned MAX_CPU       = 4;
  localparam int unsigned BULK_MASK_BIT = 11;
  localparam int unsigned BULK_PEND_BIT = 10;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASK,
    RD_PEND,
    RD_RAW,
    RD_RAW32,
    RD_ERR
  } rd_sel_e;
endpackage

// File: rtl/irq_csr_decode.sv
`timescale 1ns/1ps
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                  req,
  input  logic                  we,
  input  logic [1:0]            size,
  input  logic [CSR_ADDR_W-1:0] addr,
  output logic                  mask_we,
  output logic [CPU_W-1:0]      cpu_sel,
  output rd_sel_e               rd_sel,
  output logic                  acc_err,
  output logic                  err_clr
);
  logic [5:0] bulk_idx;
  logic [3:0] reg_num;
  logic       full;
  logic       bulk_ok;
  logic       grp_ok;
  logic       unused_low;

  assign bulk_idx   = addr[9:4];
  assign reg_num    = addr[9:6];
  assign full       = (acc_size_e'(size) == SZ_64);
  assign bulk_ok    = (32'(bulk_idx) < NUM_CPU);
  assign grp_ok     = (32'(reg_num[1:0]) < NUM_CPU);
  assign unused_low = ^addr[3:0];

  always_comb begin
    mask_we = 1'b0;
    cpu_sel = '0;
    rd_sel  = RD_NONE;
    acc_err = 1'b0;
    err_clr = 1'b0;
    if (req) begin
      if (addr[BULK_MASK_BIT]) begin
        if (full && bulk_ok) begin
          cpu_sel = CPU_W'(bulk_idx);
          if (we) mask_we = 1'b1;
          else    rd_sel  = RD_MASK;
        end else acc_err = 1'b1;
      end else if (addr[BULK_PEND_BIT]) begin
        if (full && bulk_ok && !we) begin
          cpu_sel = CPU_W'(bulk_idx);
          rd_sel  = RD_PEND;
        end else acc_err = 1'b1;
      end else begin
        case (reg_num[3:2])
          2'b00: begin
            if (full && grp_ok) begin
              cpu_sel = CPU_W'(reg_num[1:0]);
              if (we) mask_we = 1'b1;
              else    rd_sel  = RD_MASK;
            end else acc_err = 1'b1;
          end
          2'b01: begin
            if (full && grp_ok && !we) begin
              cpu_sel = CPU_W'(reg_num[1:0]);
              rd_sel  = RD_PEND;
            end else acc_err = 1'b1;
          end
          2'b10: begin
            if (reg_num[1:0] == 2'b00) begin
              if (we)                              acc_err = 1'b1;
              else if (full)                       rd_sel  = RD_RAW;
              else if (acc_size_e'(size) == SZ_32) rd_sel  = RD_RAW32;
              else                                 acc_err = 1'b1;
            end else if (reg_num[1:0] == 2'b01) begin
              if (!full)   acc_err = 1'b1;
              else if (we) err_clr = 1'b1;
              else         rd_sel  = RD_ERR;
            end else acc_err = 1'b1;
          end
          default: acc_err = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_line_latch.sv
`timescale 1ns/1ps
module irq_line_latch #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_vld,
  input  logic [LINE_W-1:0]    set_idx,
  input  logic                 clr_vld,
  input  logic [LINE_W-1:0]    clr_idx,
  output logic [NUM_LINES-1:0] raw_d,
  output logic [NUM_LINES-1:0] raw_q
);
  logic raw_en;

  assign raw_en = set_vld | clr_vld;

  // the clear goes in first, so a set on the same line wins
  always_comb begin
    raw_d = raw_q;
    if (clr_vld && (32'(clr_idx) < NUM_LINES)) raw_d[clr_idx] = 1'b0;
    if (set_vld && (32'(set_idx) < NUM_LINES)) raw_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/irq_cpu_route.sv
`timescale 1ns/1ps
module irq_cpu_route #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] raw_d,
  input  logic [NUM_LINES-1:0] raw_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pend,
  output logic                 irq_q
);
  logic [NUM_LINES-1:0] mask_d;
  logic                 irq_d;

  // the output follows next-state values, so it moves at the same edge as the state
  assign mask_d = mask_we ? wdata : mask_q;
  assign irq_d  = |(mask_d & raw_d);
  assign pend   = mask_q & raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned LINE_W = $clog2(NUM_LINES),
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dev_set_vld,
  input  logic [LINE_W-1:0]     dev_set_idx,
  input  logic                  dev_clr_vld,
  input  logic [LINE_W-1:0]     dev_clr_idx,
  input  logic                  csr_req,
  input  logic                  csr_we,
  input  logic [1:0]            csr_size,
  input  logic [CSR_ADDR_W-1:0] csr_addr,
  input  logic [CSR_DATA_W-1:0] csr_wdata,
  output logic [CSR_DATA_W-1:0] csr_rdata,
  output logic [NUM_CPU-1:0]    cpu_irq
);
  // NUM_CPU is limited to MAX_CPU and NUM_LINES to CSR_DATA_W by the register layout

  logic [NUM_LINES-1:0]         raw_d;
  logic [NUM_LINES-1:0]         raw_q;
  logic [CSR_DATA_W-1:0]        raw_ext;
  logic [NUM_LINES-1:0]         mask_q [NUM_CPU];
  logic [NUM_LINES-1:0]         pend   [NUM_CPU];
  logic [NUM_CPU-1:0]           pend_any;
  logic [NUM_CPU*NUM_LINES-1:0] mask_flat;
  logic                         mask_we;
  logic [CPU_W-1:0]             cpu_sel;
  rd_sel_e                      rd_sel;
  logic                         acc_err;
  logic                         err_clr;
  logic                         err_d;
  logic                         err_q;

  irq_csr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .req     (csr_req),
    .we      (csr_we),
    .size    (csr_size),
    .addr    (csr_addr),
    .mask_we (mask_we),
    .cpu_sel (cpu_sel),
    .rd_sel  (rd_sel),
    .acc_err (acc_err),
    .err_clr (err_clr)
  );

  irq_line_latch #(.NUM_LINES(NUM_LINES)) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (dev_set_vld),
    .set_idx (dev_set_idx),
    .clr_vld (dev_clr_vld),
    .clr_idx (dev_clr_idx),
    .raw_d   (raw_d),
    .raw_q   (raw_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_route #(.NUM_LINES(NUM_LINES)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (mask_we && (cpu_sel == CPU_W'(c))),
      .wdata   (csr_wdata[NUM_LINES-1:0]),
      .raw_d   (raw_d),
      .raw_q   (raw_q),
      .mask_q  (mask_q[c]),
      .pend    (pend[c]),
      .irq_q   (cpu_irq[c])
    );
    assign pend_any[c] = |pend[c];
    assign mask_flat[c*NUM_LINES +: NUM_LINES] = mask_q[c];
  end

  always_comb begin
    err_d = err_q;
    if (acc_err)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err_q <= 1'b0;
    else if (acc_err | err_clr) err_q <= err_d;
  end

  assign raw_ext = CSR_DATA_W'(raw_q);

  always_comb begin
    csr_rdata = '0;
    case (rd_sel)
      RD_MASK:  csr_rdata = CSR_DATA_W'(mask_q[cpu_sel]);
      RD_PEND:  csr_rdata = CSR_DATA_W'(pend[cpu_sel]);
      RD_RAW:   csr_rdata = raw_ext;
      RD_RAW32: csr_rdata = {32'b0, raw_ext[31:0]};
      RD_ERR:   csr_rdata = {{(CSR_DATA_W-1){1'b0}}, err_q};
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned LINE_W    = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         dev_set_vld,
  input logic [LINE_W-1:0]            dev_set_idx,
  input logic                         dev_clr_vld,
  input logic [LINE_W-1:0]            dev_clr_idx,
  input logic                         csr_req,
  input logic                         csr_we,
  input logic [1:0]                   csr_size,
  input logic [NUM_LINES-1:0]         raw_q,
  input logic [NUM_CPU-1:0]           cpu_irq,
  input logic [NUM_CPU-1:0]           pend_any,
  input logic [NUM_CPU*NUM_LINES-1:0] mask_flat,
  input logic                         err_q,
  input logic                         err_clr
);
  // R5
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == pend_any);

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_set_vld |=> raw_q[$past(dev_set_idx)]);

  // R4
  spurious_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr_vld && !dev_set_vld && !raw_q[dev_clr_idx] && !csr_req)
      |=> ($stable(raw_q) && $stable(cpu_irq)));

  // R8
  bad_size_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && csr_size != 2'd3) |=> (err_q && $stable(mask_flat)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

bind irq_router irq_router_chk #(
  .NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dev_set_vld(dev_set_vld), .dev_set_idx(dev_set_idx),
  .dev_clr_vld(dev_clr_vld), .dev_clr_idx(dev_clr_idx),
  .csr_req(csr_req), .csr_we(csr_we), .csr_size(csr_size),
  .raw_q(raw_q), .cpu_irq(cpu_irq), .pend_any(pend_any),
  .mask_flat(mask_flat), .err_q(err_q), .err_clr(err_clr)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NCPU  = 4;
  localparam int NLINE = 64;
  localparam int K_ERR = 0, K_MASK = 1, K_PEND = 2, K_RAW = 3, K_RAW32 = 4, K_EREG = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_set_vld, dev_clr_vld;
  logic [5:0]  dev_set_idx, dev_clr_idx;
  logic        csr_req, csr_we;
  logic [1:0]  csr_size;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic [3:0]  cpu_irq;

  logic [63:0] m_mask [NCPU];
  logic [63:0] m_raw;
  logic        m_err;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;

  irq_router #(.NUM_CPU(NCPU), .NUM_LINES(NLINE)) uut (
    .clk(clk), .rst_n(rst_n),
    .dev_set_vld(dev_set_vld), .dev_set_idx(dev_set_idx),
    .dev_clr_vld(dev_clr_vld), .dev_clr_idx(dev_clr_idx),
    .csr_req(csr_req), .csr_we(csr_we), .csr_size(csr_size),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < NCPU; c++) r[c] = |(m_mask[c] & m_raw);
    return r;
  endfunction

  function automatic int classify(logic we, logic [1:0] sz, logic [11:0] a, output int cpu);
    int idx;
    int rn;
    idx = int'(a[9:4]);
    rn  = int'(a[9:6]);
    cpu = 0;
    if (a[11]) begin
      if (sz != 2'd3 || idx >= NCPU) return K_ERR;
      cpu = idx; return K_MASK;
    end
    if (a[10]) begin
      if (sz != 2'd3 || idx >= NCPU || we) return K_ERR;
      cpu = idx; return K_PEND;
    end
    if (rn < 4) begin
      if (sz != 2'd3) return K_ERR;
      cpu = rn; return K_MASK;
    end
    if (rn < 8) begin
      if (sz != 2'd3 || we) return K_ERR;
      cpu = rn - 4; return K_PEND;
    end
    if (rn == 8) begin
      if (we) return K_ERR;
      if (sz == 2'd3) return K_RAW;
      if (sz == 2'd2) return K_RAW32;
      return K_ERR;
    end
    if (rn == 9) begin
      if (sz != 2'd3) return K_ERR;
      return K_EREG;
    end
    return K_ERR;
  endfunction

  task automatic csr_acc(string tag, logic we, logic [1:0] sz, logic [11:0] a, logic [63:0] wd);
    int cpu;
    int k;
    logic [63:0] exp_rd;
    k = classify(we, sz, a, cpu);
    exp_rd = '0;
    if (!we) begin
      case (k)
        K_MASK:  exp_rd = m_mask[cpu];
        K_PEND:  exp_rd = m_mask[cpu] & m_raw;
        K_RAW:   exp_rd = m_raw;
        K_RAW32: exp_rd = {32'b0, m_raw[31:0]};
        K_EREG:  exp_rd = {63'b0, m_err};
        default: exp_rd = '0;
      endcase
    end
    @(negedge clk);
    csr_req = 1'b1; csr_we = we; csr_size = sz; csr_addr = a; csr_wdata = wd;
    #1;
    chk({tag, " rdata"}, csr_rdata, exp_rd);
    @(posedge clk);
    #1;
    csr_req = 1'b0; csr_we = 1'b0;
    if (k == K_ERR) m_err = 1'b1;
    else if (we && k == K_MASK) m_mask[cpu] = wd;
    else if (we && k == K_EREG) m_err = 1'b0;
    @(negedge clk);
    chk({tag, " R5 irq"}, 64'(cpu_irq), 64'(exp_irq()));
  endtask

  task automatic dev_op(string tag, logic sv, logic [5:0] si, logic cv, logic [5:0] ci);
    @(negedge clk);
    dev_set_vld = sv; dev_set_idx = si; dev_clr_vld = cv; dev_clr_idx = ci;
    @(posedge clk);
    #1;
    dev_set_vld = 1'b0; dev_clr_vld = 1'b0;
    if (cv) m_raw[ci] = 1'b0;
    if (sv) m_raw[si] = 1'b1;
    @(negedge clk);
    chk({tag, " R5 irq"}, 64'(cpu_irq), 64'(exp_irq()));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] irq_before;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    dev_set_vld = 1'b0; dev_clr_vld = 1'b0; dev_set_idx = '0; dev_clr_idx = '0;
    csr_req = 1'b0; csr_we = 1'b0; csr_size = 2'd3; csr_addr = '0; csr_wdata = '0;
    for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
    m_raw = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 64'(cpu_irq), 64'h0);
    rst_n = 1'b1;

    // R1: all state zero after reset
    for (int c = 0; c < NCPU; c++) csr_acc("R1 mask", 1'b0, 2'd3, 12'(c << 6), '0);
    csr_acc("R1 raw", 1'b0, 2'd3, 12'h200, '0);
    csr_acc("R1 err", 1'b0, 2'd3, 12'h240, '0);
    // R10: idle read data
    chk("R10 idle rdata", csr_rdata, 64'h0);

    // R3 / R6: line raised, no mask yet
    dev_op("R3 set line5", 1'b1, 6'd5, 1'b0, 6'd0);
    csr_acc("R3 raw after set", 1'b0, 2'd3, 12'h200, '0);
    chk("R6 no mask no irq", 64'(cpu_irq), 64'h0);

    // R5: mask write posts to cpu1 at the same edge
    csr_acc("R5 mask1 wr", 1'b1, 2'd3, 12'h040, (64'd1 << 5) | (64'd1 << 9));
    chk("R5 cpu1 posted", 64'(cpu_irq), 64'h2);
    csr_acc("R2 pend1", 1'b0, 2'd3, 12'h140, '0);

    // R6: mask bit with raw clear does not post
    csr_acc("R6 mask2 wr", 1'b1, 2'd3, 12'h080, 64'd1 << 9);
    chk("R6 cpu2 quiet", 64'(cpu_irq[2]), 64'h0);

    // R4: spurious clear
    irq_before = cpu_irq;
    dev_op("R4 spurious clr", 1'b0, 6'd0, 1'b1, 6'd9);
    chk("R4 irq unchanged", 64'(cpu_irq), 64'(irq_before));
    csr_acc("R4 raw unchanged", 1'b0, 2'd3, 12'h200, '0);

    // R5: last pending bit removed
    dev_op("R5 clr line5", 1'b0, 6'd0, 1'b1, 6'd5);
    chk("R5 cpu1 dropped", 64'(cpu_irq), 64'h0);

    // R3: set and clear same line, set wins
    dev_op("R3 set+clr same", 1'b1, 6'd7, 1'b1, 6'd7);
    csr_acc("R3 set wins", 1'b0, 2'd3, 12'h200, '0);

    // R8: 32-bit raw read with a high bit present
    dev_op("R8 set line40", 1'b1, 6'd40, 1'b0, 6'd0);
    csr_acc("R8 raw32", 1'b0, 2'd2, 12'h200, '0);
    csr_acc("R8 raw64", 1'b0, 2'd3, 12'h200, '0);

    // R8 / R9: bad size, sticky, clear
    csr_acc("R8 half read mask", 1'b0, 2'd1, 12'h040, '0);
    csr_acc("R9 err set", 1'b0, 2'd3, 12'h240, '0);
    csr_acc("R8 byte write mask", 1'b1, 2'd0, 12'h0C0, 64'hFFFF);
    csr_acc("R8 mask3 unchanged", 1'b0, 2'd3, 12'h0C0, '0);
    csr_acc("R9 err clear", 1'b1, 2'd3, 12'h240, '0);
    csr_acc("R9 err cleared", 1'b0, 2'd3, 12'h240, '0);

    // R7: bulk windows
    csr_acc("R7 bulk mask3 wr", 1'b1, 2'd3, 12'h830, (64'd1 << 40) | 64'h80);
    csr_acc("R7 mask3 via regnum", 1'b0, 2'd3, 12'h0C0, '0);
    csr_acc("R7 bulk pend3", 1'b0, 2'd3, 12'h430, '0);
    csr_acc("R7 bit11 beats bit10", 1'b1, 2'd3, 12'hC20, 64'd1 << 7);
    csr_acc("R7 mask2 via regnum", 1'b0, 2'd3, 12'h080, '0);
    csr_acc("R7 pend0 via regnum", 1'b0, 2'd3, 12'h100, '0);

    // R9: illegal targets
    csr_acc("R9 bulk idx4", 1'b0, 2'd3, 12'h840, '0);
    csr_acc("R9 err after idx", 1'b0, 2'd3, 12'h240, '0);
    csr_acc("R9 clear", 1'b1, 2'd3, 12'h240, '0);
    csr_acc("R9 write pend", 1'b1, 2'd3, 12'h140, 64'hFFFF);
    csr_acc("R9 mask1 untouched", 1'b0, 2'd3, 12'h040, '0);
    csr_acc("R9 undefined reg", 1'b0, 2'd3, 12'h280, '0);
    csr_acc("R8 raw32 write", 1'b1, 2'd2, 12'h200, 64'h1);
    csr_acc("R9 err read", 1'b0, 2'd3, 12'h240, '0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [11:0] a;
      logic [1:0] sz;
      sel = int'($urandom % 4);
      if (sel == 0) begin
        dev_op("R3 random strobe", 1'($urandom), 6'($urandom), 1'($urandom), 6'($urandom));
      end else begin
        case ($urandom % 3)
          0:       a = {2'b00, 4'($urandom), 6'($urandom)};
          1:       a = {1'b1, 1'($urandom), 6'($urandom % 8), 4'($urandom)};
          default: a = {2'b01, 6'($urandom % 8), 4'($urandom)};
        endcase
        sz = (($urandom % 4) == 0) ? 2'($urandom) : 2'd3;
        csr_acc("R2 R7 R9 random", 1'($urandom), sz, a, {$urandom, $urandom});
      end
    end
    csr_acc("R9 final err", 1'b0, 2'd3, 12'h240, '0);
    for (int c = 0; c < NCPU; c++) csr_acc("R2 final pend", 1'b0, 2'd3, 12'(12'h100 + (c << 6)), '0);

    summary();
    $finish;
  end
endmodule